// File: doc/BRIEF.md
# Dual-Channel Phase Lock Detector with Output Selection

This block judges, for each of two frequency-synthesizer loops, whether the loop has settled, and drives one lock indicator. It is clocked by the reference oscillator. It watches a shared reference-divider pulse and one divided-channel pulse per channel. For every reference period it measures how far apart the two rising edges fall, in oscillator cycles.

A channel is declared locked only after a run of consecutive comparisons in which the two edges landed close together. Any single wide comparison, or a missing channel pulse, throws the channel back to unlocked at once. A channel placed in standby is treated as locked, and its history is wiped. Two select bits choose whether the indicator shows nothing, either channel alone, or the AND of both.

Pulse inputs are synchronous to the oscillator clock. Only rising edges matter, so a pulse may last one or more cycles.

Top module: `lockdet_top`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, both channel histories are empty. `lock_o` is therefore low for every select value when neither channel is in standby.
- R2: A comparison counts as in phase when the channel edge and the reference edge are less than TOL_CYCLES (default 2) oscillator cycles apart. This holds in either arrival order, and edges in the same cycle count as 0 cycles apart. A gap of 2 or more cycles is out of phase.
- R3: A channel reports locked only after more than LOCK_RUN (default 3) consecutive in-phase comparisons, i.e. from the 4th onward.
- R4: A single out-of-phase comparison makes that channel report unlocked immediately and restarts its run from zero.
- R5: If a reference edge opens a measurement and the next reference edge arrives before any channel edge, that comparison counts as out of phase. A new measurement starts from that second reference edge.
- R6: `standby_i[0]` (channel 1) and `standby_i[1]` (channel 2) each force their channel to report locked while high. They also clear its run, so the channel must earn lock again after leaving standby.
- R7: `sel_i` = 2'b00 drives `lock_o` low, 2'b01 shows channel 2, 2'b10 shows channel 1, and 2'b11 shows the AND of both channels.
- R8: With both channels in standby, every select value other than 2'b00 drives `lock_o` high.
- R9: The in-phase run saturates, so a channel stays locked through any number of further in-phase comparisons.
- R10: A channel's lock state changes on the clock edge that samples the edge closing its comparison. `sel_i` and `standby_i` act on `lock_o` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc_i | input | 1 | Reference oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_pulse_i | input | 1 | Reference divider output pulse, shared by both channels |
| div_pulse_i | input | 2 | Divided channel pulses; bit 0 channel 1, bit 1 channel 2 |
| standby_i | input | 2 | Standby per channel; bit 0 channel 1, bit 1 channel 2 |
| sel_i | input | 2 | Indicator source select (see R7) |
| lock_o | output | 1 | Lock indicator |

## Verification
A comparison resolves on the clock edge that samples the later of the two pulses, and the channel state moves on that same edge. The bench therefore drives every pulse at a falling edge and checks `lock_o` only at the falling edge after a whole reference period, when all comparisons of that period are settled. One directed test samples the falling edges just before and just after the closing edge of the fourth in-phase comparison, to pin down the single-edge latency. Select and standby changes are checked one time step after they are applied, because they reach `lock_o` without a register.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        MEAS_IDLE     = 2'd0,
        MEAS_WAIT_DIV = 2'd1,
        MEAS_WAIT_REF = 2'd2
    } meas_state_e;

    typedef struct packed {
        logic valid;
        logic in_phase;
    } cmp_res_t;

    // sel[1] enables channel 1, sel[0] enables channel 2; 00 forces low
    function automatic logic route_lock(input logic [1:0] sel,
                                        input logic ch1_lock,
                                        input logic ch2_lock);
        return (|sel) & (~sel[1] | ch1_lock) & (~sel[0] | ch2_lock);
    endfunction

endpackage

// File: rtl/lockdet_phase_meas.sv
module lockdet_phase_meas
    import lockdet_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int TOL_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  logic     ref_edge,
    input  logic     div_pulse,
    output cmp_res_t res
);

    localparam logic [CNT_W-1:0] TOL = CNT_W'(TOL_CYCLES);

    logic              div_prev;
    logic              div_edge;
    meas_state_e       state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n, cnt_inc;
    logic              close_ok;

    assign div_edge = div_pulse & ~div_prev;
    assign cnt_inc  = (cnt == '1) ? cnt : cnt + 1'b1;
    assign close_ok = (cnt < TOL);

    always_comb begin
        state_n      = state;
        cnt_n        = cnt;
        res.valid    = 1'b0;
        res.in_phase = 1'b0;
        if (hold) begin
            state_n = MEAS_IDLE;
            cnt_n   = '0;
        end else begin
            unique case (state)
                MEAS_IDLE: begin
                    if (ref_edge && div_edge) begin
                        res.valid    = 1'b1;
                        res.in_phase = 1'b1;
                    end else if (ref_edge) begin
                        state_n = MEAS_WAIT_DIV;
                        cnt_n   = CNT_W'(1);
                    end else if (div_edge) begin
                        state_n = MEAS_WAIT_REF;
                        cnt_n   = CNT_W'(1);
                    end
                end
                MEAS_WAIT_DIV: begin
                    if (div_edge) begin
                        res.valid    = 1'b1;
                        res.in_phase = close_ok;
                        state_n      = ref_edge ? MEAS_WAIT_DIV : MEAS_IDLE;
                        cnt_n        = ref_edge ? CNT_W'(1) : '0;
                    end else if (ref_edge) begin
                        // channel pulse never came: stale comparison
                        res.valid = 1'b1;
                        cnt_n     = CNT_W'(1);
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                MEAS_WAIT_REF: begin
                    if (ref_edge) begin
                        res.valid    = 1'b1;
                        res.in_phase = close_ok;
                        state_n      = div_edge ? MEAS_WAIT_REF : MEAS_IDLE;
                        cnt_n        = div_edge ? CNT_W'(1) : '0;
                    end else if (div_edge) begin
                        res.valid = 1'b1;
                        cnt_n     = CNT_W'(1);
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                default: begin
                    state_n = MEAS_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= MEAS_IDLE;
            cnt      <= '0;
            div_prev <= 1'b0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            div_prev <= div_pulse;
        end
    end

    assert_coincident_in_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (!hold && state == MEAS_IDLE && ref_edge && div_edge) |-> (res.valid && res.in_phase));

    assert_missing_pulse_timeout_R5: assert property (@(posedge clk) disable iff (rst)
        (!hold && state == MEAS_WAIT_DIV && ref_edge && !div_edge) |-> (res.valid && !res.in_phase));

    assert_hold_parks_measure_R6: assert property (@(posedge clk) disable iff (rst)
        hold |=> (state == MEAS_IDLE && cnt == '0));

endmodule

// File: rtl/lockdet_streak.sv
module lockdet_streak
    import lockdet_pkg::*;
#(
    parameter int LOCK_RUN = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  cmp_res_t res,
    output logic     locked
);

    localparam int NEED = LOCK_RUN + 1;
    localparam int SW   = $clog2(NEED + 1);
    localparam logic [SW-1:0] FULL = SW'(NEED);

    logic [SW-1:0] streak;
    logic          full;

    assign full   = (streak == FULL);
    assign locked = hold | full;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            streak <= '0;
        end else if (res.valid) begin
            if (!res.in_phase) begin
                streak <= '0;
            end else if (!full) begin
                streak <= streak + 1'b1;
            end
        end
    end

    assert_lock_needs_good_compare_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(res.valid && res.in_phase));

    assert_bad_compare_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (res.valid && !res.in_phase) |=> !full);

    assert_standby_clears_run_R6: assert property (@(posedge clk) disable iff (rst)
        hold |=> (streak == '0));

    assert_run_saturates_R9: assert property (@(posedge clk) disable iff (rst)
        streak <= FULL);

endmodule

// File: rtl/lockdet_out_sel.sv
module lockdet_out_sel
    import lockdet_pkg::*;
(
    input  logic [NUM_CH-1:0] ch_lock,
    input  logic [1:0]        sel,
    output logic              lock_out
);

    assign lock_out = route_lock(sel, ch_lock[0], ch_lock[1]);

endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
    import lockdet_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int TOL_CYCLES = 2,
    parameter int LOCK_RUN   = 3
) (
    input  logic              clk_osc_i,
    input  logic              rst_i,
    input  logic              ref_pulse_i,
    input  logic [NUM_CH-1:0] div_pulse_i,
    input  logic [NUM_CH-1:0] standby_i,
    input  logic [1:0]        sel_i,
    output logic              lock_o
);

    logic              ref_prev;
    logic              ref_edge;
    logic [NUM_CH-1:0] ch_lock;

    assign ref_edge = ref_pulse_i & ~ref_prev;

    always_ff @(posedge clk_osc_i) begin
        if (rst_i) ref_prev <= 1'b0;
        else       ref_prev <= ref_pulse_i;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cmp_res_t res;

        lockdet_phase_meas #(
            .CNT_W      (CNT_W),
            .TOL_CYCLES (TOL_CYCLES)
        ) i_meas (
            .clk       (clk_osc_i),
            .rst       (rst_i),
            .hold      (standby_i[c]),
            .ref_edge  (ref_edge),
            .div_pulse (div_pulse_i[c]),
            .res       (res)
        );

        lockdet_streak #(
            .LOCK_RUN (LOCK_RUN)
        ) i_streak (
            .clk    (clk_osc_i),
            .rst    (rst_i),
            .hold   (standby_i[c]),
            .res    (res),
            .locked (ch_lock[c])
        );
    end

    lockdet_out_sel i_sel (
        .ch_lock  (ch_lock),
        .sel      (sel_i),
        .lock_out (lock_o)
    );

    assert_sel_off_low_R7: assert property (@(posedge clk_osc_i) disable iff (rst_i)
        (sel_i == 2'b00) |-> !lock_o);

    assert_both_standby_high_R8: assert property (@(posedge clk_osc_i) disable iff (rst_i)
        (standby_i == 2'b11 && sel_i != 2'b00) |-> lock_o);

    assert_reset_unlocked_R1: assert property (@(posedge clk_osc_i)
        ($past(rst_i) && standby_i == 2'b00) |-> !lock_o);

endmodule

// File: tb/test_lockdet_top.sv
module test_lockdet_top;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 12;   // oscillator cycles per reference period
    localparam int BASE       = 4;    // reference pulse position in period
    localparam int MISS       = 99;   // offset code: no channel pulse
    localparam int NROWS      = 24;

    // row = {off_ch1[7:0], off_ch2[7:0], standby[1:0], sel[1:0], expected}
    localparam logic [20:0] TBL [NROWS] = '{
        {8'd0,   8'd0,   2'b00, 2'b11, 1'b0},  //  0 run 1/1
        {8'd1,   8'hFF,  2'b00, 2'b11, 1'b0},  //  1 +1 / -1 in phase, run 2
        {8'hFF,  8'd0,   2'b00, 2'b11, 1'b0},  //  2 run 3, not yet
        {8'd0,   8'd1,   2'b00, 2'b11, 1'b1},  //  3 run 4: locked
        {8'd1,   8'd1,   2'b00, 2'b11, 1'b1},  //  4 saturated, still locked
        {8'd2,   8'd0,   2'b00, 2'b11, 1'b0},  //  5 ch1 gap 2: out of phase
        {8'd0,   8'd0,   2'b00, 2'b01, 1'b1},  //  6 show ch2
        {8'd0,   8'd0,   2'b00, 2'b10, 1'b0},  //  7 show ch1 (run 2)
        {8'd0,   8'hFE,  2'b00, 2'b01, 1'b0},  //  8 ch2 gap -2
        {8'd0,   8'd0,   2'b00, 2'b10, 1'b1},  //  9 ch1 run 4
        {8'd0,   8'd0,   2'b00, 2'b00, 1'b0},  // 10 select off
        {8'd0,   8'd99,  2'b00, 2'b10, 1'b1},  // 11 ch2 pulse missing
        {8'd0,   8'd1,   2'b00, 2'b01, 1'b0},  // 12 ch2 timed out, run 1
        {8'd0,   8'd0,   2'b00, 2'b01, 1'b0},  // 13 ch2 run 2
        {8'd0,   8'd0,   2'b11, 2'b01, 1'b1},  // 14 both standby
        {8'd0,   8'd0,   2'b11, 2'b10, 1'b1},  // 15
        {8'd0,   8'd0,   2'b11, 2'b11, 1'b1},  // 16
        {8'd0,   8'd0,   2'b11, 2'b00, 1'b0},  // 17
        {8'd0,   8'd0,   2'b01, 2'b11, 1'b0},  // 18 ch1 standby, ch2 run 1
        {8'd0,   8'd0,   2'b01, 2'b10, 1'b1},  // 19 ch1 standby shows high
        {8'd0,   8'd0,   2'b00, 2'b10, 1'b0},  // 20 ch1 restarts at run 1
        {8'd0,   8'd0,   2'b00, 2'b01, 1'b1},  // 21 ch2 run 4
        {8'd0,   8'd5,   2'b00, 2'b01, 1'b0},  // 22 ch2 gap 5
        {8'd0,   8'd0,   2'b00, 2'b10, 1'b1}   // 23 ch1 run 4
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       ref_pulse;
    logic [1:0] div_pulse;
    logic [1:0] standby;
    logic [1:0] sel;
    logic       lock;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockdet_top i_lockdet_top (
        .clk_osc_i   (clk),
        .rst_i       (rst),
        .ref_pulse_i (ref_pulse),
        .div_pulse_i (div_pulse),
        .standby_i   (standby),
        .sel_i       (sel),
        .lock_o      (lock)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic drive_slot(input int k, input int o1, input int o2);
        ref_pulse    = (k == BASE);
        div_pulse[0] = (o1 != MISS) && (k == BASE + o1);
        div_pulse[1] = (o2 != MISS) && (k == BASE + o2);
    endtask

    // called at a falling edge; returns at a falling edge one period later
    task automatic run_period(input int o1, input int o2);
        for (int k = 0; k < P; k++) begin
            drive_slot(k, o1, o2);
            @(negedge clk);
        end
        ref_pulse = 1'b0;
        div_pulse = 2'b00;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        ref_pulse = 1'b0;
        div_pulse = 2'b00;
        standby   = 2'b00;
        sel       = 2'b11;
        rst       = 1'b1;
        @(negedge clk);
        do_reset();

        // R1: empty history after reset, each select value
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            #1;
            check(lock, 1'b0, "R1 reset state");
        end

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int r = 0; r < NROWS; r++) begin
            int o1;
            int o2;
            o1      = int'($signed(TBL[r][20:13]));
            o2      = int'($signed(TBL[r][12:5]));
            standby = TBL[r][4:3];
            sel     = TBL[r][2:1];
            run_period(o1, o2);
            check(lock, TBL[r][0], $sformatf("R2/R3/R4/R5/R6/R7/R8/R9 row %0d", r));
        end

        // R8: both in standby right after a fresh reset, no history at all
        do_reset();
        standby = 2'b11;
        for (int s = 1; s < 4; s++) begin
            sel = 2'(s);
            #1;
            check(lock, 1'b1, "R8 both standby");
        end
        standby = 2'b00;
        #1;
        check(lock, 1'b0, "R6 leaving standby shows empty run");

        // R10: edge-exact lock on the 4th in-phase comparison
        sel = 2'b10;
        repeat (3) run_period(0, 0);
        for (int k = 0; k <= BASE; k++) begin
            drive_slot(k, 0, 0);
            if (k == BASE) check(lock, 1'b0, "R3 unlocked before 4th close");
            @(negedge clk);
        end
        check(lock, 1'b1, "R10 locked after closing edge");
        for (int k = BASE + 1; k < P; k++) begin
            drive_slot(k, 0, 0);
            @(negedge clk);
        end
        ref_pulse = 1'b0;
        div_pulse = 2'b00;

        // R1: reset while locked
        rst = 1'b1;
        @(negedge clk);
        check(lock, 1'b0, "R1 reset clears lock");
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule